// File: doc/BRIEF.md
# Serial Host-Link Controller

This block connects a processor's word-register interface to a bit-serial link between a host and a packet switch. Software sees three registers at consecutive word addresses above a configurable base: a control/status word, an output word and an input word. Writing the output word starts an outgoing byte that is shifted out one bit at a time. Incoming bits are packed into a byte that the processor collects from the input word. Each completed byte, in either direction, can raise an interrupt.

Every serial bit is moved with a two-wire handshake. The receiving side signals that it is ready for a bit, and the sending side presents the data bit with a strobe. A bit is taken on a clock edge where both are high. The receiver stops at a full byte or at an early end-of-message indication. It then stays frozen until software reads the input word. The output word also carries commands that open or close the host-ready relay, and the input word reports relay check inputs and a sticky "switch was down" flag.

Top module: `hostlink_ctrl`

## Requirements
- R1: After a synchronous reset, the control/status word reads 0, `irq` is low, `rx_ready` and `tx_strobe` are low, and `host_relay_close` is low (the relay is open).
- R2: The registers decode at BASE+0 (control/status), BASE+2 (output) and BASE+4 (input), with BASE defaulting to 16'hEFF8. Control/status bits: [0] transmit enable, [1] transmit interrupt enable, [4] receive enable and [5] receive interrupt enable are read/write. [2] transmit done and [7] receive done are read-only. Every other bit reads 0.
- R3: `rx_ready` is high exactly when receive is enabled and receive done is clear. A bit is taken on a clock edge with `rx_ready` and `rx_strobe` both high, and bits are shifted in from the low end, so the first bit of a full byte ends in input bit [7].
- R4: The receiver sets receive done after its eighth bit, or earlier on a bit taken with `rx_last` high. Input bit [8] then holds `rx_last` of the final bit. An early stop after n bits leaves those bits right-aligned in input bits [7:0].
- R5: While receive done is set, `rx_strobe` pulses change neither the byte, the last flag nor the done flag.
- R6: A read of the input word returns the byte with its flags. It then clears the byte, the bit count, the last flag and receive done, which re-arms reception.
- R7: Input bit [9] is set on any cycle with `imp_down` high and stays set until an input-word read (that read still returns 1). Bits [10] and [11] show the `host_relay_chk_n` and `imp_relay_chk_n` levels (0 = closed).
- R8: A write to the output word while transmit is enabled and idle loads bits [7:0], clears transmit done and raises `tx_strobe` with the most significant bit on `tx_bit_out`. The link advances one bit per clock edge with `tx_ready` high and holds while `tx_ready` is low.
- R9: When output bit [14] was written as 1, `tx_last` is high during the eighth bit only. After the eighth bit is taken, `tx_strobe` drops and transmit done is set.
- R10: An output-word write with bit [12] alone sets `host_relay_close`, and one with bit [13] alone clears it. Writing both leaves it unchanged. Output bit [12] reads back the relay state.
- R11: `irq` = (receive done AND receive interrupt enable) OR (transmit done AND transmit interrupt enable).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address of the word |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while bus_sel is high |
| rx_bit | input | 1 | Incoming serial data bit |
| rx_strobe | input | 1 | Incoming bit present |
| rx_last | input | 1 | Incoming bit is the last of the message |
| rx_ready | output | 1 | Receiver ready for next bit |
| tx_bit_out | output | 1 | Outgoing serial data bit |
| tx_strobe | output | 1 | Outgoing bit present |
| tx_last | output | 1 | Outgoing bit is the last of the message |
| tx_ready | input | 1 | Far end ready for next bit |
| imp_down | input | 1 | Switch-down indication |
| host_relay_chk_n | input | 1 | Host relay check, 0 = closed |
| imp_relay_chk_n | input | 1 | Switch relay check, 0 = closed |
| host_relay_close | output | 1 | Host-ready relay command, 1 = closed |
| irq | output | 1 | Interrupt request |

## Verification
Assertions check several properties on every cycle. A frozen receiver keeps its byte and flags. Receive done rises only after an accepted strobe. A stalled transmitter keeps its shift state. A double relay command leaves the relay unchanged. The interrupt is never raised without a done flag. The bench scenarios are needed for the values themselves. These include the bit order and right-alignment of early-stopped bytes, the last-bit marker arriving with the eighth outgoing bit, the read-then-clear behaviour of the sticky down flag, and the register map as seen over the bus.

// File: rtl/hostlink_pkg.sv
package hostlink_pkg;

    localparam int unsigned BYTE_W = 8;

    localparam int unsigned OFS_CSR = 0;
    localparam int unsigned OFS_OUT = 2;
    localparam int unsigned OFS_IN  = 4;

    localparam int unsigned CSR_TX_EN   = 0;
    localparam int unsigned CSR_TX_IE   = 1;
    localparam int unsigned CSR_TX_DONE = 2;
    localparam int unsigned CSR_RX_EN   = 4;
    localparam int unsigned CSR_RX_IE   = 5;
    localparam int unsigned CSR_RX_DONE = 7;

    localparam int unsigned OUT_CLOSE = 12;
    localparam int unsigned OUT_OPEN  = 13;
    localparam int unsigned OUT_LAST  = 14;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CSR,
        SEL_OUT,
        SEL_IN
    } reg_sel_e;

    typedef struct packed {
        logic rx_ie;
        logic rx_en;
        logic tx_ie;
        logic tx_en;
    } ctl_t;

    function automatic logic [15:0] pack_csr(ctl_t c, logic tx_done, logic rx_done);
        logic [15:0] w;
        w = '0;
        w[CSR_TX_EN]   = c.tx_en;
        w[CSR_TX_IE]   = c.tx_ie;
        w[CSR_TX_DONE] = tx_done;
        w[CSR_RX_EN]   = c.rx_en;
        w[CSR_RX_IE]   = c.rx_ie;
        w[CSR_RX_DONE] = rx_done;
        return w;
    endfunction

endpackage

// File: rtl/hostlink_rx.sv
module hostlink_rx #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         clr,
    input  logic         bit_in,
    input  logic         strobe,
    input  logic         last_in,
    output logic         ready,
    output logic         done,
    output logic         last_flag,
    output logic [W-1:0] data
);
    localparam int unsigned CW = $clog2(W + 1);

    logic [CW-1:0] cnt;
    logic          take;

    assign ready = en && !done;
    assign take  = ready && strobe;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            data      <= '0;
            cnt       <= '0;
            done      <= 1'b0;
            last_flag <= 1'b0;
        end else if (take) begin
            data <= {data[W-2:0], bit_in};
            cnt  <= cnt + 1'b1;
            if (cnt == CW'(W - 1) || last_in) begin
                done      <= 1'b1;
                last_flag <= last_in;
            end
        end
    end

    // R5: a stopped receiver keeps its contents until cleared
    assert_rx_frozen_R5: assert property (@(posedge clk) disable iff (rst)
        (done && !clr) |=> (done && $stable(data) && $stable(last_flag)));

    // R4: done only rises after an accepted strobe
    assert_rx_done_cause_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(strobe && en));

endmodule

// File: rtl/hostlink_tx.sv
module hostlink_tx #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] din,
    input  logic         last_req,
    input  logic         ready_in,
    output logic         bit_out,
    output logic         strobe,
    output logic         last_out,
    output logic         done
);
    localparam int unsigned CW = $clog2(W + 1);

    logic [W-1:0]  sh;
    logic [CW-1:0] cnt;
    logic          busy;
    logic          lreq;
    logic          final_bit;

    assign final_bit = (cnt == CW'(W - 1));
    assign strobe    = busy;
    assign bit_out   = sh[W-1];
    assign last_out  = busy && lreq && final_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            cnt  <= '0;
            busy <= 1'b0;
            lreq <= 1'b0;
            done <= 1'b0;
        end else if (!busy) begin
            if (start) begin
                sh   <= din;
                cnt  <= '0;
                busy <= 1'b1;
                lreq <= last_req;
                done <= 1'b0;
            end
        end else if (ready_in) begin
            sh  <= {sh[W-2:0], 1'b0};
            cnt <= cnt + 1'b1;
            if (final_bit) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end
    end

    // R8: without the far end ready the bit in flight holds
    assert_tx_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && !ready_in) |=> (busy && $stable(sh) && $stable(cnt)));

    // R9: done never coexists with a byte in flight
    assert_tx_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

endmodule

// File: rtl/hostlink_relay.sv
module hostlink_relay (
    input  logic clk,
    input  logic rst,
    input  logic wr,
    input  logic open_cmd,
    input  logic close_cmd,
    output logic closed
);
    always_ff @(posedge clk) begin
        if (rst) begin
            closed <= 1'b0;
        end else if (wr && (open_cmd != close_cmd)) begin
            closed <= close_cmd;
        end
    end

    // R10: conflicting command leaves the relay alone
    assert_relay_both_R10: assert property (@(posedge clk) disable iff (rst)
        (wr && open_cmd && close_cmd) |=> $stable(closed));

    // R10: a lone open command opens
    assert_relay_open_R10: assert property (@(posedge clk) disable iff (rst)
        (wr && open_cmd && !close_cmd) |=> !closed);

endmodule

// File: rtl/hostlink_ctrl.sv
module hostlink_ctrl
    import hostlink_pkg::*;
#(
    parameter int unsigned    AW   = 16,
    parameter logic [AW-1:0]  BASE = AW'(16'hEFF8)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [15:0]   bus_wdata,
    output logic [15:0]   bus_rdata,
    input  logic          rx_bit,
    input  logic          rx_strobe,
    input  logic          rx_last,
    output logic          rx_ready,
    output logic          tx_bit_out,
    output logic          tx_strobe,
    output logic          tx_last,
    input  logic          tx_ready,
    input  logic          imp_down,
    input  logic          host_relay_chk_n,
    input  logic          imp_relay_chk_n,
    output logic          host_relay_close,
    output logic          irq
);
    localparam logic [AW-1:0] ADDR_CSR = BASE + AW'(OFS_CSR);
    localparam logic [AW-1:0] ADDR_OUT = BASE + AW'(OFS_OUT);
    localparam logic [AW-1:0] ADDR_IN  = BASE + AW'(OFS_IN);

    reg_sel_e           sel;
    ctl_t               ctl;
    logic               wr_csr, wr_out, rd_in;
    logic               rx_done, rx_lastf, tx_done;
    logic [BYTE_W-1:0]  rx_data;
    logic               down_sticky;
    logic               unused_wdata;

    assign unused_wdata = ^{bus_wdata[15], bus_wdata[11:8]};

    always_comb begin
        sel = SEL_NONE;
        if (bus_sel) begin
            if (bus_addr == ADDR_CSR)      sel = SEL_CSR;
            else if (bus_addr == ADDR_OUT) sel = SEL_OUT;
            else if (bus_addr == ADDR_IN)  sel = SEL_IN;
        end
    end

    assign wr_csr = bus_wr && (sel == SEL_CSR);
    assign wr_out = bus_wr && (sel == SEL_OUT);
    assign rd_in  = !bus_wr && (sel == SEL_IN);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else if (wr_csr) begin
            ctl.tx_en <= bus_wdata[CSR_TX_EN];
            ctl.tx_ie <= bus_wdata[CSR_TX_IE];
            ctl.rx_en <= bus_wdata[CSR_RX_EN];
            ctl.rx_ie <= bus_wdata[CSR_RX_IE];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            down_sticky <= 1'b0;
        end else if (rd_in) begin
            down_sticky <= imp_down;
        end else if (imp_down) begin
            down_sticky <= 1'b1;
        end
    end

    hostlink_rx #(.W(BYTE_W)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .en        (ctl.rx_en),
        .clr       (rd_in),
        .bit_in    (rx_bit),
        .strobe    (rx_strobe),
        .last_in   (rx_last),
        .ready     (rx_ready),
        .done      (rx_done),
        .last_flag (rx_lastf),
        .data      (rx_data)
    );

    hostlink_tx #(.W(BYTE_W)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .start    (wr_out && ctl.tx_en),
        .din      (bus_wdata[BYTE_W-1:0]),
        .last_req (bus_wdata[OUT_LAST]),
        .ready_in (tx_ready),
        .bit_out  (tx_bit_out),
        .strobe   (tx_strobe),
        .last_out (tx_last),
        .done     (tx_done)
    );

    hostlink_relay u_relay (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr_out),
        .open_cmd  (bus_wdata[OUT_OPEN]),
        .close_cmd (bus_wdata[OUT_CLOSE]),
        .closed    (host_relay_close)
    );

    always_comb begin
        bus_rdata = '0;
        if (!bus_wr) begin
            case (sel)
                SEL_CSR: bus_rdata = pack_csr(ctl, tx_done, rx_done);
                SEL_OUT: bus_rdata[OUT_CLOSE] = host_relay_close;
                SEL_IN:  bus_rdata = {4'b0000, imp_relay_chk_n, host_relay_chk_n,
                                      down_sticky, rx_lastf, rx_data};
                default: bus_rdata = '0;
            endcase
        end
    end

    assign irq = (rx_done && ctl.rx_ie) || (tx_done && ctl.tx_ie);

    // R11: an interrupt always has a done flag behind it
    assert_irq_source_R11: assert property (@(posedge clk) disable iff (rst)
        irq |-> (rx_done || tx_done));

    // R7: the sticky down flag is set after any down cycle not consumed by a read
    assert_down_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (imp_down && !rd_in) |=> down_sticky);

endmodule

// File: tb/hostlink_ctrl_bench.sv
module hostlink_ctrl_bench;

    localparam logic [15:0] A_CSR = 16'hEFF8;
    localparam logic [15:0] A_OUT = 16'hEFFA;
    localparam logic [15:0] A_IN  = 16'hEFFC;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_sel, bus_wr;
    logic [15:0] bus_addr, bus_wdata, bus_rdata;
    logic        rx_bit, rx_strobe, rx_last, rx_ready;
    logic        tx_bit_out, tx_strobe, tx_last, tx_ready;
    logic        imp_down, host_relay_chk_n, imp_relay_chk_n;
    logic        host_relay_close, irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    hostlink_ctrl u_hostlink_ctrl (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_bit(rx_bit), .rx_strobe(rx_strobe), .rx_last(rx_last), .rx_ready(rx_ready),
        .tx_bit_out(tx_bit_out), .tx_strobe(tx_strobe), .tx_last(tx_last), .tx_ready(tx_ready),
        .imp_down(imp_down), .host_relay_chk_n(host_relay_chk_n),
        .imp_relay_chk_n(imp_relay_chk_n),
        .host_relay_close(host_relay_close), .irq(irq)
    );

    // rx vectors: {bit count, last flag, pattern}
    localparam logic [12:0] RXV [7] = '{
        {4'd8, 1'b0, 8'hA5},
        {4'd8, 1'b1, 8'h3C},
        {4'd3, 1'b1, 8'hE0},
        {4'd1, 1'b1, 8'h80},
        {4'd5, 1'b1, 8'h5A},
        {4'd8, 1'b0, 8'h00},
        {4'd8, 1'b0, 8'hFF}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic send_bit(input logic b, input logic l);
        @(negedge clk);
        rx_bit = b; rx_last = l; rx_strobe = 1'b1;
        @(negedge clk);
        rx_strobe = 1'b0; rx_last = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] rd, rd2;
        logic [7:0]  txb;
        logic        saw_last;
        rst = 1'b1; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        rx_bit = 0; rx_strobe = 0; rx_last = 0; tx_ready = 0;
        imp_down = 0; host_relay_chk_n = 1'b0; imp_relay_chk_n = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 irq", {15'b0, irq}, 16'h0000);
        chk("R1 rx_ready", {15'b0, rx_ready}, 16'h0000);
        chk("R1 tx_strobe", {15'b0, tx_strobe}, 16'h0000);
        chk("R1 relay", {15'b0, host_relay_close}, 16'h0000);
        bus_read(A_CSR, rd);
        chk("R1 csr", rd, 16'h0000);

        // R2 read/write mask and read-only done bits
        bus_write(A_CSR, 16'hFFFF);
        bus_read(A_CSR, rd);
        chk("R2 csr mask", rd, 16'h0033);
        bus_read(16'hEFFE, rd);
        chk("R2 unmapped", rd, 16'h0000);

        // R3 R4 R6 R11: table of receive patterns
        for (int v = 0; v < 7; v++) begin
            int unsigned n;
            logic        lf;
            logic [7:0]  pat, expb;
            n   = RXV[v][12:9];
            lf  = RXV[v][8];
            pat = RXV[v][7:0];
            expb = pat >> (8 - n);
            chk("R3 ready before byte", {15'b0, rx_ready}, 16'h0001);
            for (int i = 0; i < int'(n); i++)
                send_bit(pat[7 - i], (i == int'(n) - 1) ? lf : 1'b0);
            chk("R3 ready drops at done", {15'b0, rx_ready}, 16'h0000);
            chk("R11 irq on rx done", {15'b0, irq}, 16'h0001);
            bus_read(A_CSR, rd);
            chk("R4 rx done bit", {15'b0, rd[7]}, 16'h0001);
            bus_read(A_IN, rd);
            chk("R4 input word", rd, {4'b0, 1'b1, 1'b0, 1'b0, lf, expb});
            chk("R6 re-armed", {15'b0, rx_ready}, 16'h0001);
            chk("R6 irq cleared", {15'b0, irq}, 16'h0000);
        end

        // R5 frozen receiver ignores strobes
        for (int i = 0; i < 8; i++) send_bit(i[0], 1'b0);
        for (int i = 0; i < 3; i++) send_bit(1'b1, 1'b1);
        bus_read(A_IN, rd);
        chk("R5 frozen byte", rd, 16'h0855);

        // R7 sticky down flag and relay checks
        @(negedge clk); imp_down = 1'b1;
        @(negedge clk); imp_down = 1'b0;
        host_relay_chk_n = 1'b1; imp_relay_chk_n = 1'b0;
        bus_read(A_IN, rd);
        chk("R7 down set", rd, 16'h0600);
        bus_read(A_IN, rd);
        chk("R7 down cleared", rd, 16'h0400);
        host_relay_chk_n = 1'b0; imp_relay_chk_n = 1'b1;

        // R11 interrupt gated by enable
        bus_write(A_CSR, 16'h0010);
        for (int i = 0; i < 8; i++) send_bit(1'b1, 1'b0);
        chk("R11 masked irq", {15'b0, irq}, 16'h0000);
        bus_write(A_CSR, 16'h0030);
        chk("R11 unmasked irq", {15'b0, irq}, 16'h0001);
        bus_read(A_IN, rd);

        // R8 R9 transmit with last marker
        bus_write(A_CSR, 16'h0003);
        bus_write(A_OUT, 16'h40C6);
        chk("R8 strobe up", {15'b0, tx_strobe}, 16'h0001);
        bus_read(A_CSR, rd);
        chk("R8 tx done cleared", {15'b0, rd[2]}, 16'h0000);
        chk("R8 held first bit", {15'b0, tx_bit_out}, 16'h0001);
        @(negedge clk);
        chk("R8 still held", {15'b0, tx_strobe & tx_bit_out}, 16'h0001);
        tx_ready = 1'b1;
        txb = '0; saw_last = 1'b0;
        for (int i = 0; i < 8; i++) begin
            txb = {txb[6:0], tx_bit_out};
            chk("R9 last marker", {15'b0, tx_last}, {15'b0, (i == 7) ? 1'b1 : 1'b0});
            @(negedge clk);
        end
        tx_ready = 1'b0;
        chk("R8 serial byte", {8'h00, txb}, 16'h00C6);
        chk("R9 strobe drops", {15'b0, tx_strobe}, 16'h0000);
        chk("R11 tx irq", {15'b0, irq}, 16'h0001);
        bus_read(A_CSR, rd);
        chk("R9 tx done", {15'b0, rd[2]}, 16'h0001);

        // R9 no marker without last flag
        bus_write(A_OUT, 16'h0035);
        tx_ready = 1'b1;
        txb = '0;
        for (int i = 0; i < 8; i++) begin
            txb = {txb[6:0], tx_bit_out};
            saw_last = saw_last | tx_last;
            @(negedge clk);
        end
        tx_ready = 1'b0;
        chk("R9 no marker", {15'b0, saw_last}, 16'h0000);
        chk("R8 second byte", {8'h00, txb}, 16'h0035);

        // R10 relay commands, transmit disabled
        bus_write(A_CSR, 16'h0000);
        bus_write(A_OUT, 16'h1000);
        chk("R10 close", {15'b0, host_relay_close}, 16'h0001);
        bus_write(A_OUT, 16'h3000);
        chk("R10 both ignored closed", {15'b0, host_relay_close}, 16'h0001);
        bus_read(A_OUT, rd);
        chk("R10 readback", rd, 16'h1000);
        bus_write(A_OUT, 16'h2000);
        chk("R10 open", {15'b0, host_relay_close}, 16'h0000);
        bus_write(A_OUT, 16'h3000);
        bus_read(A_OUT, rd2);
        chk("R10 both ignored open", {rd2[15:1], host_relay_close}, 16'h0000);
        chk("R10 no tx when disabled", {15'b0, tx_strobe}, 16'h0000);

        finish_run();
    end

endmodule